// File: doc/BRIEF.md
# Pipelined Lookahead Binary Up Counter

This block is an 8-bit synchronous binary up counter. Its value matches a plain incrementing register on every cycle, but no combinational carry chain runs from the low bits to the high bits. The count is split into four 2-bit slices. The lowest slice counts whenever counting is enabled. Each of the three upper slices is stepped by an enable that comes straight from a flip-flop.

The flip-flops that drive these enables form short prediction pipelines. Each pipeline starts at a small compare on the lowest slice. It fires a fixed number of cycles before the carry is due, one cycle for each pipeline stage. At each later stage, the pipeline also takes in the "all ones" state of one intermediate slice. Because of this, no gate in the enable logic needs more than three inputs, and the delay of each stage does not grow as slices are added. All slices change together on the same rising edge.

The counter suits high-rate event counting and clock division, where the carry path would otherwise limit the clock frequency. A single count-enable input pauses both the count and the prediction pipelines, and a synchronous reset clears both.

Top module: `lookahead_counter`

## Requirements
- R1: While `rst` is high at a rising edge, `count` becomes 0 after that edge, and every prediction flip-flop is cleared as well.
- R2: With `rst` low and `cnt_en` high at a rising edge, `count` becomes the previous value plus one.
- R3: With `rst` low and `cnt_en` low at a rising edge, `count` keeps its value. When counting resumes, it continues from that value with no lost or extra step.
- R4: From 8'hFF, an enabled edge gives 8'h00, and counting then continues normally.
- R5: The slice for bits [3:2] steps exactly on the enabled edges where bits [1:0] are 2'b11.
- R6: The slices for bits [5:4] and [7:6] step exactly on the enabled edges where every bit below them is one. For example, 8'h0F goes to 8'h10, 8'h3F goes to 8'h40, and 8'h7F goes to 8'h80.
- R7: A reset applied in the middle of a count, while predictions are in flight, is followed by a correct count sequence from 0.
- R8: Pausing the count at any cycle, including the cycles just before a carry into an upper slice, does not cause a wrong prediction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable; low freezes count and predictions |
| count | output | 8 | Current count value |

## Verification
The hardest case to reach is a pause, or a reset, that lands while a prediction for an upper slice is already inside its pipeline. Only at that point could a stale prediction step a slice on the wrong edge. The stimulus counts up to values just below each carry point (8'h02, 8'h0E, 8'h3D, 8'hFE and others) and holds the enable low there for several cycles before resuming. It also applies a reset at 8'h3D, and it runs a long pseudo-random enable pattern. The output is compared with a reference count on every cycle across more than two full wraps.

// File: rtl/lac_pkg.sv
package lac_pkg;

    localparam int LAC_CNT_W = 8;
    localparam int LAC_MOD_W = 2;

    // Low-slice value from which the prediction chain for upper slice k starts.
    // The chain has k+1 stages, so it must start k+1 counts before all ones.
    function automatic int lac_first_tap(input int mod_w, input int k);
        return (1 << mod_w) - 2 - k;
    endfunction

endpackage

// File: rtl/lac_low_cnt.sv
module lac_low_cnt #(
    parameter int MOD_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [MOD_W-1:0] cnt_q
);
    logic [MOD_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (en) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/lac_up_cnt.sv
module lac_up_cnt #(
    parameter int MOD_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [MOD_W-1:0] cnt_q,
    output logic             sat
);
    logic [MOD_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (en) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    // slice is at all ones; used by the prediction pipelines
    assign sat = &cnt_q;
endmodule

// File: rtl/lac_lookahead.sv
module lac_lookahead
    import lac_pkg::*;
#(
    parameter int MOD_W  = 2,
    parameter int NUM_UP = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [MOD_W-1:0]  low_q,
    input  logic [NUM_UP-1:0] sat_i,
    output logic [NUM_UP-1:0] en_up_o
);
    // stg[k][j]: stage j of the chain feeding upper slice k.
    // Entries with j > k are not used and stay zero.
    typedef struct packed {
        logic [NUM_UP-1:0][NUM_UP-1:0] stg;
    } la_state_t;

    la_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            for (int k = 0; k < NUM_UP; k++) begin
                for (int j = 0; j < NUM_UP; j++) begin
                    if (j > k)
                        st_d.stg[k][j] = 1'b0;
                    else if (j == 0)
                        st_d.stg[k][j] = (low_q == MOD_W'(lac_first_tap(MOD_W, k)));
                    else
                        // slice j-1 cannot move here: low slice is not yet all ones
                        st_d.stg[k][j] = st_q.stg[k][j-1] & sat_i[j-1];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_UP; g++) begin : g_en
        assign en_up_o[g] = en & st_q.stg[g][g];
    end
endmodule

// File: rtl/lookahead_counter.sv
module lookahead_counter
    import lac_pkg::*;
#(
    parameter int CNT_W = LAC_CNT_W,
    parameter int MOD_W = LAC_MOD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    output logic [CNT_W-1:0] count
);
    localparam int NUM_UP = CNT_W / MOD_W - 1;

    logic [MOD_W-1:0]             low_q;
    logic [NUM_UP-1:0][MOD_W-1:0] up_q;
    logic [NUM_UP-1:0]            up_sat;
    logic [NUM_UP-1:0]            en_up;

    lac_low_cnt #(.MOD_W(MOD_W)) u_low (
        .clk   (clk),
        .rst   (rst),
        .en    (cnt_en),
        .cnt_q (low_q)
    );

    for (genvar g = 0; g < NUM_UP; g++) begin : g_up
        lac_up_cnt #(.MOD_W(MOD_W)) u_up (
            .clk   (clk),
            .rst   (rst),
            .en    (en_up[g]),
            .cnt_q (up_q[g]),
            .sat   (up_sat[g])
        );
    end

    lac_lookahead #(.MOD_W(MOD_W), .NUM_UP(NUM_UP)) u_la (
        .clk     (clk),
        .rst     (rst),
        .en      (cnt_en),
        .low_q   (low_q),
        .sat_i   (up_sat),
        .en_up_o (en_up)
    );

    assign count = {up_q, low_q};
endmodule

// File: rtl/lac_checker.sv
module lac_checker #(
    parameter int CNT_W  = 8,
    parameter int NUM_UP = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              cnt_en,
    input logic [CNT_W-1:0]  count,
    input logic [NUM_UP-1:0] en_up
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (count == '0));

    a_r2_increment: assert property (@(posedge clk) disable iff (rst)
        cnt_en |=> (count == CNT_W'($past(count) + 1'b1)));

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(count));

    a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && count == '1) |=> (count == '0));

    a_r5_mid_enable: assert property (@(posedge clk) disable iff (rst)
        en_up[0] == (cnt_en && count[1:0] == 2'b11));

    a_r6_slice2_enable: assert property (@(posedge clk) disable iff (rst)
        en_up[1] == (cnt_en && count[3:0] == 4'hF));

    a_r6_slice3_enable: assert property (@(posedge clk) disable iff (rst)
        en_up[2] == (cnt_en && count[5:0] == 6'h3F));
endmodule

bind lookahead_counter lac_checker #(.CNT_W(CNT_W), .NUM_UP(NUM_UP)) u_lac_chk (
    .clk    (clk),
    .rst    (rst),
    .cnt_en (cnt_en),
    .count  (count),
    .en_up  (en_up)
);

// File: tb/test_lookahead_counter.sv
`timescale 1ns/1ps
module test_lookahead_counter;
    logic       clk = 1'b0;
    logic       rst;
    logic       cnt_en;
    logic [7:0] count;
    logic [7:0] ref_cnt;
    int         checks   = 0;
    int         failures = 0;
    bit         done     = 1'b0;

    always #2 clk = ~clk;

    lookahead_counter i_lookahead_counter (
        .clk    (clk),
        .rst    (rst),
        .cnt_en (cnt_en),
        .count  (count)
    );

    // {rst, cnt_en, expected count after the edge}
    localparam logic [9:0] VEC [12] = '{
        {1'b0, 1'b1, 8'd1}, {1'b0, 1'b1, 8'd2}, {1'b0, 1'b0, 8'd2},
        {1'b0, 1'b1, 8'd3}, {1'b0, 1'b1, 8'd4}, {1'b0, 1'b0, 8'd4},
        {1'b0, 1'b0, 8'd4}, {1'b0, 1'b1, 8'd5}, {1'b1, 1'b1, 8'd0},
        {1'b0, 1'b1, 8'd1}, {1'b0, 1'b1, 8'd2}, {1'b0, 1'b1, 8'd3}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s count=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive at negedge, clock once, compare at the next negedge
    task automatic step(input logic r, input logic e);
        rst    = r;
        cnt_en = e;
        @(posedge clk);
        if (r)      ref_cnt = 8'd0;
        else if (e) ref_cnt = ref_cnt + 8'd1;
        @(negedge clk);
    endtask

    task automatic run_to(input logic [7:0] target);
        while (ref_cnt != target) step(1'b0, 1'b1);
    endtask

    initial begin
        logic [7:0] lfsr;
        logic [7:0] taps [6];
        rst = 1'b1; cnt_en = 1'b0; ref_cnt = 8'd0;
        @(negedge clk);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        check("R1", count, 8'd0);

        // table walk: R1 reset with enable high, R2 counting, R3 holding
        for (int i = 0; i < 12; i++) begin
            step(VEC[i][9], VEC[i][8]);
            ref_cnt = VEC[i][7:0];
            check(VEC[i][9] ? "R1" : (VEC[i][8] ? "R2" : "R3"), count, VEC[i][7:0]);
        end

        // R5 carry into bits [3:2]
        run_to(8'h03);
        step(1'b0, 1'b1);
        check("R5", count, 8'h04);
        run_to(8'h07);
        step(1'b0, 1'b1);
        check("R5", count, 8'h08);

        // R6 carries into bits [5:4] and [7:6]
        run_to(8'h0F); step(1'b0, 1'b1); check("R6", count, 8'h10);
        run_to(8'h3F); step(1'b0, 1'b1); check("R6", count, 8'h40);
        run_to(8'h7F); step(1'b0, 1'b1); check("R6", count, 8'h80);

        // R2 / R4: more than two full wraps, compared every cycle
        for (int i = 0; i < 600; i++) begin
            step(1'b0, 1'b1);
            check(ref_cnt == 8'h00 ? "R4" : "R2", count, ref_cnt);
        end

        // R8: pauses just before carry points
        taps = '{8'h02, 8'h0E, 8'h3D, 8'h3E, 8'hFD, 8'hFE};
        for (int t = 0; t < 6; t++) begin
            run_to(taps[t]);
            for (int p = 0; p < 3; p++) begin
                step(1'b0, 1'b0);
                check("R8", count, ref_cnt);
            end
            for (int p = 0; p < 4; p++) begin
                step(1'b0, 1'b1);
                check("R8", count, ref_cnt);
            end
        end

        // R3: pseudo-random enable pattern
        lfsr = 8'hA5;
        for (int i = 0; i < 1500; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(1'b0, lfsr[0] | lfsr[2]);
            check("R3", count, ref_cnt);
        end

        // R7: reset with predictions in flight
        run_to(8'h3D);
        step(1'b1, 1'b1);
        check("R7", count, 8'h00);
        for (int i = 0; i < 300; i++) begin
            step(1'b0, 1'b1);
            check("R7", count, ref_cnt);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired count=%0h expected=done", count);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule